// File: doc/BRIEF.md
# Counter Channel Interrupt Hub

This block collects event strobes from a bank of counter channels and turns them into one shared, active-high interrupt request. Every channel owns a bit in a mask register and a bit in a sticky pending register. A strobe is recorded only when the channel's mask bit is set and the global interrupt function is armed. The request line is the OR of the pending bits, and it is held low while the interrupt function is disarmed.

Software reaches the block through a small 8-bit register port. The mask register can be written and read back. The pending register is read-only. A command register accepts two global codes. The arm code turns the interrupt function on and clears every pending bit in one step. The disarm code turns the function off and sends a one-cycle reset pulse to the counter channels. Pending bits cannot be cleared one at a time. The only way to clear them is the arm command, which also re-enables the request line.

Top module: `cnt_irq_hub`

## Requirements
- R1: While reset is held and on the first cycle after it, the pending register, the mask register and the interrupt function are all zero, `irq_out` is low and `cnt_clear` is low.
- R2: A write to offset 0x12 loads the mask register, with bit n belonging to channel n. A read of offset 0x12 returns the value last written.
- R3: Pending bit n, read at offset 0x10, goes to 1 on the clock edge where `ch_event[n]` is high, mask bit n is 1 and the interrupt function is armed. A strobe that arrives while the mask bit is 0 or the function is disarmed is not recorded.
- R4: A pending bit stays at 1 until an arm command. A write to offset 0x10 changes nothing.
- R5: Writing 0x04 to offset 0x11 arms the interrupt function and clears all pending bits on that clock edge.
- R6: If a channel strobe that would be recorded arrives in the same cycle as the arm command, that channel's pending bit is 1 after the edge.
- R7: Writing 0x01 to offset 0x11 disarms the interrupt function and leaves the pending bits unchanged. On the next cycle only, `cnt_clear` is high.
- R8: `irq_out` is high exactly when the function is armed and at least one pending bit is 1. When the pending register reads zero, `irq_out` is low.
- R9: Writing any value other than 0x01 or 0x04 to offset 0x11 has no effect. Reads of offset 0x11, or of any offset with no register, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_event | input | NUM_CH (8) | Per-channel event strobes, one bit per channel |
| reg_addr | input | ADDR_W (5) | Register offset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Shared interrupt request, active high |
| cnt_clear | output | 1 | One-cycle pulse telling the counter channels to reset |

## Verification
The assertions assume that `ch_event` and the register strobes are clean synchronous signals. They also assume that a write selects only one offset per cycle, so an arm command and a disarm command can never fall in the same cycle. The stimulus changes inputs only at falling edges and issues one write per step. The stimulus also lines up a strobe with an arm command on purpose, to exercise the priority rule. Strobes are sent in the masked, unmasked and disarmed states, so every clause of the recording condition is covered.

// File: rtl/cnt_irq_pkg.sv
package cnt_irq_pkg;
   localparam int unsigned HUB_DATA_W = 8;

   typedef enum logic [HUB_DATA_W-1:0] {
      CMD_DISARM_RST = 8'h01,
      CMD_ARM_CLR    = 8'h04
   } hub_cmd_e;
endpackage

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl
   import cnt_irq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   parameter logic [ADDR_W-1:0] MASK_OFS = 5'h12,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] mask_q,
   output logic              armed_q,
   output logic              arm_cmd,
   output logic              disarm_cmd,
   output logic              cnt_clr_q
);
   logic mask_wr;
   logic cmd_wr;

   assign mask_wr    = we && (addr == MASK_OFS);
   assign cmd_wr     = we && (addr == CMD_OFS);
   assign arm_cmd    = cmd_wr && (wdata == DATA_W'(CMD_ARM_CLR));
   assign disarm_cmd = cmd_wr && (wdata == DATA_W'(CMD_DISARM_RST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         armed_q   <= 1'b0;
         cnt_clr_q <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= wdata[NUM_CH-1:0];
         if (arm_cmd)         armed_q <= 1'b1;
         else if (disarm_cmd) armed_q <= 1'b0;
         cnt_clr_q <= disarm_cmd;
      end
   end
endmodule

// File: rtl/cnt_irq_pending.sv
module cnt_irq_pending #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_event,
   input  logic [NUM_CH-1:0] mask_q,
   input  logic              armed_q,
   input  logic              clr,
   output logic [NUM_CH-1:0] pend_q
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
      logic hit;
      assign hit = ch_event[ch] && mask_q[ch] && armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   pend_q[ch] <= 1'b0;
         else if (hit) pend_q[ch] <= 1'b1;
         else if (clr) pend_q[ch] <= 1'b0;
      end
   end
endmodule

// File: rtl/cnt_irq_rdmux.sv
module cnt_irq_rdmux #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] PEND_OFS = 5'h10,
   parameter logic [ADDR_W-1:0] MASK_OFS = 5'h12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NUM_CH-1:0] pend_q,
   input  logic [NUM_CH-1:0] mask_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] pend_ext;
   logic [DATA_W-1:0] mask_ext;

   if (NUM_CH == DATA_W) begin : g_full
      assign pend_ext = pend_q;
      assign mask_ext = mask_q;
   end else begin : g_pad
      assign pend_ext = {{(DATA_W-NUM_CH){1'b0}}, pend_q};
      assign mask_ext = {{(DATA_W-NUM_CH){1'b0}}, mask_q};
   end

   always_comb begin
      rdata = '0;
      if (addr == PEND_OFS)      rdata = pend_ext;
      else if (addr == MASK_OFS) rdata = mask_ext;
   end
endmodule

// File: rtl/cnt_irq_hub.sv
module cnt_irq_hub #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] PEND_OFS = 5'h10,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h11,
   parameter logic [ADDR_W-1:0] MASK_OFS = 5'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_event,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out,
   output logic              cnt_clear
);
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_width
      $error("cnt_irq_hub: NUM_CH must lie in 1..DATA_W");
   end
   if (DATA_W != cnt_irq_pkg::HUB_DATA_W) begin : g_bad_data
      $error("cnt_irq_hub: DATA_W must match the command code width");
   end
   if (PEND_OFS == CMD_OFS || PEND_OFS == MASK_OFS || CMD_OFS == MASK_OFS) begin : g_bad_map
      $error("cnt_irq_hub: register offsets must differ");
   end

   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] pend_q;
   logic              armed_q;
   logic              arm_cmd;
   logic              disarm_cmd;

   cnt_irq_ctrl #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MASK_OFS(MASK_OFS), .CMD_OFS(CMD_OFS)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .mask_q(mask_q), .armed_q(armed_q), .arm_cmd(arm_cmd),
      .disarm_cmd(disarm_cmd), .cnt_clr_q(cnt_clear)
   );

   cnt_irq_pending #(.NUM_CH(NUM_CH)) pend_i (
      .clk(clk), .rst_n(rst_n), .ch_event(ch_event), .mask_q(mask_q),
      .armed_q(armed_q), .clr(arm_cmd), .pend_q(pend_q)
   );

   cnt_irq_rdmux #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PEND_OFS(PEND_OFS), .MASK_OFS(MASK_OFS)
   ) rd_i (
      .addr(reg_addr), .pend_q(pend_q), .mask_q(mask_q), .rdata(reg_rdata)
   );

   assign irq_out = armed_q && (|pend_q);
endmodule

// File: rtl/cnt_irq_hub_chk.sv
module cnt_irq_hub_chk #(
   parameter int unsigned NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_event,
   input logic [NUM_CH-1:0] pend,
   input logic [NUM_CH-1:0] mask,
   input logic              armed,
   input logic              arm,
   input logic              disarm,
   input logic              irq
);
   // R3
   set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(ch_event & mask & {NUM_CH{armed}})) == '0);

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(arm) |-> ((pend & $past(pend)) == $past(pend)));

   // R5
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm) |-> ((pend & ~$past(ch_event)) == '0));

   // R8
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq);

   // R7
   disarm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(disarm) |-> (!irq && !armed));

   // R6
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm && armed) |-> ((pend & $past(ch_event & mask)) == $past(ch_event & mask)));
endmodule

bind cnt_irq_hub cnt_irq_hub_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .ch_event(ch_event), .pend(pend_q), .mask(mask_q),
   .armed(armed_q), .arm(arm_cmd), .disarm(disarm_cmd), .irq(irq_out)
);

// File: tb/cnt_irq_hub_tb_top.sv
`timescale 1ns/1ps
module cnt_irq_hub_tb_top;
   localparam logic [4:0] A_PEND = 5'h10;
   localparam logic [4:0] A_CMD  = 5'h11;
   localparam logic [4:0] A_MASK = 5'h12;

   typedef struct packed {
      logic       we;
      logic [4:0] addr;
      logic [7:0] wdata;
      logic [7:0] ev;
      logic [7:0] exp_pend;
      logic       exp_irq;
   } step_t;

   localparam int NSTEP = 15;
   localparam step_t STEPS [NSTEP] = '{
      '{1'b0, A_PEND, 8'h00, 8'hFF, 8'h00, 1'b0}, // R3 no mask, disarmed
      '{1'b1, A_MASK, 8'h0F, 8'h00, 8'h00, 1'b0}, // R2
      '{1'b0, A_PEND, 8'h00, 8'h03, 8'h00, 1'b0}, // R3 masked in but disarmed
      '{1'b1, A_CMD,  8'h04, 8'h00, 8'h00, 1'b0}, // R5 arm
      '{1'b0, A_PEND, 8'h00, 8'h81, 8'h01, 1'b1}, // R3 only masked-in bit
      '{1'b0, A_PEND, 8'h00, 8'h30, 8'h01, 1'b1}, // R3 masked-out bits
      '{1'b1, A_MASK, 8'hFF, 8'h00, 8'h01, 1'b1}, // R2
      '{1'b0, A_PEND, 8'h00, 8'h30, 8'h31, 1'b1}, // R3 R8
      '{1'b1, A_PEND, 8'h00, 8'h00, 8'h31, 1'b1}, // R4 write ignored
      '{1'b1, A_CMD,  8'h02, 8'h00, 8'h31, 1'b1}, // R9 unknown code
      '{1'b1, A_CMD,  8'h01, 8'h00, 8'h31, 1'b0}, // R7 disarm keeps pending
      '{1'b0, A_PEND, 8'h00, 8'h40, 8'h31, 1'b0}, // R3 disarmed strobe
      '{1'b1, A_CMD,  8'h04, 8'h00, 8'h00, 1'b0}, // R5 clear
      '{1'b1, A_CMD,  8'h04, 8'h08, 8'h08, 1'b1}, // R6 strobe wins
      '{1'b1, A_CMD,  8'h04, 8'h00, 8'h00, 1'b0}  // R5 R8
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ch_event = '0;
   logic [4:0] reg_addr = A_PEND;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_out;
   logic       cnt_clear;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   cnt_irq_hub dut_i (
      .clk(clk), .rst_n(rst_n), .ch_event(ch_event), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .cnt_clear(cnt_clear)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h want %02h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [4:0] a, output logic [7:0] d);
      reg_we = 1'b0;
      ch_event = '0;
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout want completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      peek(A_PEND, d); check("R1 pending", d, 8'h00);
      check("R1 irq", {7'd0, irq_out}, 8'h00);
      check("R1 cnt_clear", {7'd0, cnt_clear}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      peek(A_MASK, d); check("R1 mask", d, 8'h00);
      check("R1 irq after release", {7'd0, irq_out}, 8'h00);

      for (int i = 0; i < NSTEP; i++) begin
         reg_we    = STEPS[i].we;
         reg_addr  = STEPS[i].addr;
         reg_wdata = STEPS[i].wdata;
         ch_event  = STEPS[i].ev;
         @(negedge clk);
         peek(A_PEND, d);
         check($sformatf("R3/R8 step %0d pending", i), d, STEPS[i].exp_pend);
         check($sformatf("R8 step %0d irq", i), {7'd0, irq_out}, {7'd0, STEPS[i].exp_irq});
      end

      // R2 readback
      peek(A_MASK, d); check("R2 mask readback", d, 8'hFF);
      // R9 reads of command and empty offsets
      peek(A_CMD, d); check("R9 cmd read", d, 8'h00);
      peek(5'h03, d); check("R9 empty read", d, 8'h00);

      // R7 counter reset pulse lasts one cycle
      reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 8'h01;
      @(negedge clk);
      peek(A_PEND, d);
      check("R7 cnt_clear high", {7'd0, cnt_clear}, 8'h01);
      @(negedge clk);
      check("R7 cnt_clear one cycle", {7'd0, cnt_clear}, 8'h00);

      // R9 unknown code must not re-arm
      reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 8'h05;
      @(negedge clk);
      reg_we = 1'b0; ch_event = 8'h02;
      @(negedge clk);
      peek(A_PEND, d); check("R9 code 05 ignored", d, 8'h00);

      // R6 with the function disarmed beforehand the strobe is not recorded
      reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 8'h04; ch_event = 8'h04;
      @(negedge clk);
      peek(A_PEND, d); check("R6 disarmed arm cycle", d, 8'h00);

      finish_run();
   end
endmodule